// File: doc/BRIEF.md
# Trace Timestamp Request Generator

This block decides when a trace source should emit timestamp information. It keeps a local elapsed-time counter that advances on a reference tick. The tick comes from one of two sources and passes through a prescaler with four selectable ratios. Software acknowledges a sent local timestamp, and that clears the counter. When the local counter holds a nonzero value, an emitted packet raises a local timestamp request.

In parallel, the block watches a free-running 48-bit global time count from elsewhere in the system. It raises a global timestamp request according to a 2-bit frequency setting. Depending on the setting, the request fires on a change in a fine or a coarse upper slice of that count, after every packet that leaves an empty output FIFO, or never. All requests are single-cycle pulses, registered one clock after the event that caused them. Packet encoding and clock-domain crossing of the global count are done by neighbouring blocks.

Top module: `ts_req_gen`

## Requirements
- R1: While reset is asserted and on the first edge after it, `lts_value` is 0 and both `lts_req` and `gts_req` are 0.
- R2: With a tick on every cycle, `presc_sel` codes 0, 1, 2 and 3 make `lts_value` advance by one every 1, 4, 16 and 64 ticks respectively, counted from a cleared prescaler.
- R3: `clk_sel` = 0 counts `sys_tick` only; `clk_sel` = 1 counts `port_tick` only; the unselected tick has no effect on `lts_value`.
- R4: While `ts_enable` is 0, `lts_value` holds, the prescaler phase is cleared and `lts_req` stays 0.
- R5: A change of `presc_sel` clears the prescaler phase, so the first advance after the change comes a full new ratio of ticks later.
- R6: `lts_ack` clears `lts_value` to 0 on the next edge and takes priority over an advance due in the same cycle.
- R7: `lts_value` is `LTS_W` bits wide (28 by default) and wraps from all ones to 0.
- R8: `lts_req` is a one-cycle pulse on the edge after a cycle with `pkt_done` = 1, `ts_enable` = 1 and a nonzero `lts_value`; it stays 0 when the counter is 0.
- R9: `gts_freq` = 0 never raises `gts_req`.
- R10: `gts_freq` = 1 pulses `gts_req` one edge after bits [47:7] of `gts_count` differ from their value in the previous cycle; changes limited to bits [6:0] raise nothing.
- R11: `gts_freq` = 2 pulses `gts_req` one edge after bits [47:13] change; changes limited to bits [12:0] raise nothing.
- R12: `gts_freq` = 3 pulses `gts_req` one edge after a cycle with `pkt_done` = 1 and `ofifo_empty` = 1; with `ofifo_empty` = 0, or with count changes alone, nothing is raised.
- R13: The first cycle after reset only captures `gts_count`: a nonzero count present at reset release raises no global request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_enable | input | 1 | Enables local timestamp counting and requests |
| clk_sel | input | 1 | Tick source select: 0 system tick, 1 trace-port tick |
| sys_tick | input | 1 | Reference tick derived from the system clock |
| port_tick | input | 1 | Reference tick from the trace-port clock, already synchronised |
| presc_sel | input | 2 | Prescale code: ratio 4^code |
| gts_freq | input | 2 | Global request mode: 0 off, 1 fine slice, 2 coarse slice, 3 per packet |
| gts_count | input | 48 | Global time count |
| pkt_done | input | 1 | Strobe: a trace packet was emitted this cycle |
| ofifo_empty | input | 1 | Output FIFO is empty |
| lts_ack | input | 1 | Local timestamp sent; clears the counter |
| lts_value | output | 28 | Local elapsed-time counter |
| lts_req | output | 1 | Local timestamp request pulse |
| gts_req | output | 1 | Global timestamp request pulse |

## Verification
The two local-counter functions that can meet in one cycle are the acknowledge clear and a prescaler advance. The bench provokes the overlap by holding the tick on at prescale 1, so that every cycle carries an advance, and then asserting `lts_ack`. The counter must read 0 after that edge rather than 1, and it must resume at 1 one edge later. A prescale change or an enable drop during a partly filled prescaler phase is also provoked, and it is judged by the exact edge of the next advance.

// File: rtl/ts_req_pkg.sv
package ts_req_pkg;

   typedef enum logic [1:0] {
      GTS_OFF    = 2'd0,
      GTS_FINE   = 2'd1,
      GTS_COARSE = 2'd2,
      GTS_PKT    = 2'd3
   } gts_mode_e;

   // Number of prescaler counter bits needed for the largest ratio.
   function automatic int unsigned presc_cnt_width(input int unsigned code_w,
                                                   input int unsigned step_log2);
      return step_log2 * ((1 << code_w) - 1);
   endfunction

endpackage

// File: rtl/ts_prescaler.sv
module ts_prescaler #(
   parameter int unsigned CODE_W    = 2,
   parameter int unsigned STEP_LOG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  logic [CODE_W-1:0] code,
   output logic              step
);
   import ts_req_pkg::*;

   localparam int unsigned CNT_W = presc_cnt_width(CODE_W, STEP_LOG2);

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("ts_prescaler: prescaler counter width must be at least 1");
      end
   endgenerate

   logic [CODE_W-1:0] code_q;
   logic [CNT_W-1:0]  pcnt;
   logic [CNT_W-1:0]  limit;
   logic              restart;
   logic              hit;

   // limit = ratio - 1 = 2^(STEP_LOG2*code) - 1, a run of low ones
   always_comb begin
      for (int i = 0; i < int'(CNT_W); i++) begin
         limit[i] = (i < int'(STEP_LOG2) * int'(code));
      end
   end

   assign restart = !en || (code != code_q);
   assign hit     = (pcnt == limit);
   assign step    = !restart && tick && hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q <= '0;
         pcnt   <= '0;
      end else begin
         code_q <= code;
         if (restart) begin
            pcnt <= '0;
         end else if (tick) begin
            pcnt <= hit ? '0 : pcnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/ts_local_cnt.sv
module ts_local_cnt #(
   parameter int unsigned W = 28
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         step,
   input  logic         ack,
   input  logic         pkt_done,
   output logic [W-1:0] value,
   output logic         req
);

   generate
      if (W < 2) begin : g_bad_w
         $error("ts_local_cnt: counter must be at least 2 bits");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         value <= '0;
         req   <= 1'b0;
      end else begin
         req <= en && pkt_done && (value != '0);
         // acknowledge wins over a concurrent advance
         if (ack) begin
            value <= '0;
         end else if (step) begin
            value <= value + 1'b1;
         end
      end
   end

endmodule

// File: rtl/ts_global_trig.sv
module ts_global_trig #(
   parameter int unsigned GTS_W      = 48,
   parameter int unsigned FINE_LSB   = 7,
   parameter int unsigned COARSE_LSB = 13
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  ts_req_pkg::gts_mode_e mode,
   input  logic [GTS_W-1:0]      gts_cur,
   input  logic                  pkt_done,
   input  logic                  ofifo_empty,
   output logic                  req
);
   import ts_req_pkg::*;

   localparam int unsigned NUM_SLICES = 2;

   logic [GTS_W-1:0]      gts_prev;
   logic [GTS_W-1:0]      diff;
   logic                  primed;
   logic [NUM_SLICES-1:0] slice_chg;
   logic                  fire;

   assign diff = gts_cur ^ gts_prev;

   // slice 0: fine range, slice 1: coarse range
   generate
      for (genvar g = 0; g < int'(NUM_SLICES); g++) begin : g_slice
         localparam int unsigned LSB = (g == 0) ? FINE_LSB : COARSE_LSB;
         assign slice_chg[g] = primed && (|(diff >> LSB));
      end
   endgenerate

   always_comb begin
      unique case (mode)
         GTS_OFF:    fire = 1'b0;
         GTS_FINE:   fire = slice_chg[0];
         GTS_COARSE: fire = slice_chg[1];
         GTS_PKT:    fire = pkt_done && ofifo_empty;
         default:    fire = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gts_prev <= '0;
         primed   <= 1'b0;
         req      <= 1'b0;
      end else begin
         gts_prev <= gts_cur;
         primed   <= 1'b1;
         req      <= fire;
      end
   end

endmodule

// File: rtl/ts_req_gen.sv
module ts_req_gen #(
   parameter int unsigned LTS_W           = 28,
   parameter int unsigned GTS_W           = 48,
   parameter int unsigned PRESC_CODE_W    = 2,
   parameter int unsigned PRESC_STEP_LOG2 = 2,
   parameter int unsigned FINE_LSB        = 7,
   parameter int unsigned COARSE_LSB      = 13
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ts_enable,
   input  logic                    clk_sel,
   input  logic                    sys_tick,
   input  logic                    port_tick,
   input  logic [PRESC_CODE_W-1:0] presc_sel,
   input  logic [1:0]              gts_freq,
   input  logic [GTS_W-1:0]        gts_count,
   input  logic                    pkt_done,
   input  logic                    ofifo_empty,
   input  logic                    lts_ack,
   output logic [LTS_W-1:0]        lts_value,
   output logic                    lts_req,
   output logic                    gts_req
);
   import ts_req_pkg::*;

   generate
      if (FINE_LSB >= COARSE_LSB) begin : g_bad_order
         $error("ts_req_gen: fine slice must start below coarse slice");
      end
      if (COARSE_LSB >= GTS_W) begin : g_bad_coarse
         $error("ts_req_gen: coarse slice lies outside the global count");
      end
   endgenerate

   logic      tick;
   logic      step;
   gts_mode_e mode;

   assign tick = clk_sel ? port_tick : sys_tick;
   assign mode = gts_mode_e'(gts_freq);

   ts_prescaler #(
      .CODE_W    (PRESC_CODE_W),
      .STEP_LOG2 (PRESC_STEP_LOG2)
   ) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ts_enable),
      .tick  (tick),
      .code  (presc_sel),
      .step  (step)
   );

   ts_local_cnt #(
      .W (LTS_W)
   ) u_lcnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ts_enable),
      .step     (step),
      .ack      (lts_ack),
      .pkt_done (pkt_done),
      .value    (lts_value),
      .req      (lts_req)
   );

   ts_global_trig #(
      .GTS_W      (GTS_W),
      .FINE_LSB   (FINE_LSB),
      .COARSE_LSB (COARSE_LSB)
   ) u_gtrig (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode        (mode),
      .gts_cur     (gts_count),
      .pkt_done    (pkt_done),
      .ofifo_empty (ofifo_empty),
      .req         (gts_req)
   );

endmodule

// File: rtl/ts_req_gen_chk.sv
module ts_req_gen_chk #(
   parameter int unsigned LTS_W = 28
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ts_enable,
   input logic [1:0]       gts_freq,
   input logic             pkt_done,
   input logic             ofifo_empty,
   input logic             lts_ack,
   input logic [LTS_W-1:0] lts_value,
   input logic             lts_req,
   input logic             gts_req
);

   a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      lts_ack |=> (lts_value == '0));

   a_r4_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!ts_enable && !lts_ack) |=> $stable(lts_value));

   a_r4_no_req_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !ts_enable |=> !lts_req);

   a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      !lts_ack |=> ((lts_value == $past(lts_value)) ||
                    (lts_value == LTS_W'($past(lts_value) + 1'b1))));

   a_r8_req_needs_pkt: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_done |=> !lts_req);

   a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (gts_freq == 2'd0) |=> !gts_req);

   a_r12_fifo_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (gts_freq == 2'd3 && !ofifo_empty) |=> !gts_req);

   a_r12_needs_pkt: assert property (@(posedge clk) disable iff (!rst_n)
      (gts_freq == 2'd3 && !pkt_done) |=> !gts_req);

endmodule

bind ts_req_gen ts_req_gen_chk #(.LTS_W(LTS_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ts_enable   (ts_enable),
   .gts_freq    (gts_freq),
   .pkt_done    (pkt_done),
   .ofifo_empty (ofifo_empty),
   .lts_ack     (lts_ack),
   .lts_value   (lts_value),
   .lts_req     (lts_req),
   .gts_req     (gts_req)
);

// File: tb/ts_req_gen_bench.sv
module ts_req_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ts_enable;
   logic        clk_sel;
   logic        sys_tick;
   logic        port_tick;
   logic [1:0]  presc_sel;
   logic [1:0]  gts_freq;
   logic [47:0] gts_count;
   logic        pkt_done;
   logic        ofifo_empty;
   logic        lts_ack;
   logic [27:0] lts_value;
   logic        lts_req;
   logic        gts_req;
   logic [3:0]  n_value;
   logic        n_lreq;
   logic        n_greq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   ts_req_gen u_ts_req_gen (
      .clk(clk), .rst_n(rst_n), .ts_enable(ts_enable), .clk_sel(clk_sel),
      .sys_tick(sys_tick), .port_tick(port_tick), .presc_sel(presc_sel),
      .gts_freq(gts_freq), .gts_count(gts_count), .pkt_done(pkt_done),
      .ofifo_empty(ofifo_empty), .lts_ack(lts_ack), .lts_value(lts_value),
      .lts_req(lts_req), .gts_req(gts_req)
   );

   ts_req_gen #(.LTS_W(4)) u_ts_req_gen_narrow (
      .clk(clk), .rst_n(rst_n), .ts_enable(ts_enable), .clk_sel(clk_sel),
      .sys_tick(sys_tick), .port_tick(port_tick), .presc_sel(presc_sel),
      .gts_freq(gts_freq), .gts_count(gts_count), .pkt_done(pkt_done),
      .ofifo_empty(ofifo_empty), .lts_ack(lts_ack), .lts_value(n_value),
      .lts_req(n_lreq), .gts_req(n_greq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // clears counter and prescaler phase; returns one negedge later with enable on
   task automatic restart(input logic [1:0] code);
      @(negedge clk);
      ts_enable = 1'b0; lts_ack = 1'b1; presc_sel = code;
      @(negedge clk);
      ts_enable = 1'b1; lts_ack = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; ts_enable = 1'b1; clk_sel = 1'b0; sys_tick = 1'b1;
      port_tick = 1'b0; presc_sel = 2'd0; gts_freq = 2'd1;
      gts_count = 48'h1234_5678_9ABC; pkt_done = 1'b0; ofifo_empty = 1'b1;
      lts_ack = 1'b0;
      wait_n(3);
      chk("R1 lts_value in reset", 64'(lts_value), 0);
      chk("R1 lts_req in reset", 64'(lts_req), 0);
      chk("R1 gts_req in reset", 64'(gts_req), 0);
      rst_n = 1'b1;
      wait_n(1);
      chk("R13 no global request on first capture", 64'(gts_req), 0);
      wait_n(1);
      chk("R13 no global request second cycle", 64'(gts_req), 0);
   endtask

   task automatic t_prescale();
      for (int c = 0; c < 4; c++) begin
         int r;
         r = 1 << (2 * c);
         restart(2'(c));
         wait_n(4 * r - 1);
         chk($sformatf("R2 code %0d before 4th advance", c), 64'(lts_value), 3);
         wait_n(1);
         chk($sformatf("R2 code %0d at 4th advance", c), 64'(lts_value), 4);
      end
   endtask

   task automatic t_source();
      clk_sel = 1'b1; sys_tick = 1'b1; port_tick = 1'b0;
      restart(2'd0);
      wait_n(5);
      chk("R3 system tick ignored when port selected", 64'(lts_value), 0);
      sys_tick = 1'b0; port_tick = 1'b1;
      wait_n(5);
      chk("R3 port tick counted", 64'(lts_value), 5);
      clk_sel = 1'b0;
      restart(2'd0);
      wait_n(4);
      chk("R3 port tick ignored when system selected", 64'(lts_value), 0);
      sys_tick = 1'b1; port_tick = 1'b0;
   endtask

   task automatic t_enable();
      restart(2'd0);
      wait_n(10);
      chk("R4 counting before disable", 64'(lts_value), 10);
      ts_enable = 1'b0;
      pkt_done = 1'b1;
      wait_n(1);
      pkt_done = 1'b0;
      chk("R4 no local request while disabled", 64'(lts_req), 0);
      wait_n(6);
      chk("R4 value held while disabled", 64'(lts_value), 10);
      restart(2'd1);
      wait_n(2);
      ts_enable = 1'b0;
      wait_n(1);
      ts_enable = 1'b1;
      wait_n(3);
      chk("R4 phase cleared, no early advance", 64'(lts_value), 0);
      wait_n(1);
      chk("R4 advance after full ratio", 64'(lts_value), 1);
   endtask

   task automatic t_presc_change();
      restart(2'd2);
      wait_n(10);
      chk("R5 mid phase at ratio 16", 64'(lts_value), 0);
      presc_sel = 2'd1;
      wait_n(4);
      chk("R5 no advance right after change", 64'(lts_value), 0);
      wait_n(1);
      chk("R5 first advance a full ratio after change", 64'(lts_value), 1);
   endtask

   task automatic t_ack();
      restart(2'd0);
      wait_n(5);
      chk("R6 count before ack", 64'(lts_value), 5);
      lts_ack = 1'b1;
      wait_n(1);
      chk("R6 ack beats concurrent advance", 64'(lts_value), 0);
      lts_ack = 1'b0;
      wait_n(1);
      chk("R6 counting resumes", 64'(lts_value), 1);
   endtask

   task automatic t_wrap();
      restart(2'd0);
      wait_n(15);
      chk("R7 narrow counter at all ones", 64'(n_value), 15);
      wait_n(1);
      chk("R7 narrow counter wraps to zero", 64'(n_value), 0);
      chk("R7 wide counter keeps going", 64'(lts_value), 16);
   endtask

   task automatic t_lreq();
      sys_tick = 1'b0;
      restart(2'd0);
      pkt_done = 1'b1;
      wait_n(1);
      pkt_done = 1'b0;
      chk("R8 no request with zero counter", 64'(lts_req), 0);
      sys_tick = 1'b1;
      wait_n(3);
      pkt_done = 1'b1;
      wait_n(1);
      pkt_done = 1'b0;
      chk("R8 request after packet", 64'(lts_req), 1);
      wait_n(1);
      chk("R8 request lasts one cycle", 64'(lts_req), 0);
   endtask

   task automatic t_gts_off();
      gts_freq = 2'd0; ofifo_empty = 1'b1;
      gts_count = 48'hFFFF_0000_0000;
      wait_n(1);
      chk("R9 count change ignored", 64'(gts_req), 0);
      pkt_done = 1'b1;
      wait_n(1);
      pkt_done = 1'b0;
      chk("R9 packet ignored", 64'(gts_req), 0);
   endtask

   task automatic t_gts_fine();
      gts_freq = 2'd1; gts_count = 48'h0;
      wait_n(2);
      chk("R10 quiet on stable count", 64'(gts_req), 0);
      gts_count = 48'h7F;
      wait_n(1);
      chk("R10 low bits change ignored", 64'(gts_req), 0);
      gts_count = 48'h80;
      wait_n(1);
      chk("R10 bit 7 change requests", 64'(gts_req), 1);
      wait_n(1);
      chk("R10 single pulse", 64'(gts_req), 0);
      gts_count = 48'h8000_0000_0080;
      wait_n(1);
      chk("R10 bit 47 change requests", 64'(gts_req), 1);
   endtask

   task automatic t_gts_coarse();
      gts_freq = 2'd2;
      wait_n(1);
      gts_count = 48'h8000_0000_1FFF;
      wait_n(1);
      chk("R11 change below bit 13 ignored", 64'(gts_req), 0);
      gts_count = 48'h8000_0000_2000;
      wait_n(1);
      chk("R11 bit 13 change requests", 64'(gts_req), 1);
      wait_n(1);
      chk("R11 single pulse", 64'(gts_req), 0);
   endtask

   task automatic t_gts_pkt();
      gts_freq = 2'd3; ofifo_empty = 1'b1;
      wait_n(1);
      pkt_done = 1'b1;
      wait_n(1);
      pkt_done = 1'b0;
      chk("R12 packet with empty FIFO requests", 64'(gts_req), 1);
      wait_n(1);
      chk("R12 single pulse", 64'(gts_req), 0);
      ofifo_empty = 1'b0; pkt_done = 1'b1;
      wait_n(1);
      pkt_done = 1'b0;
      chk("R12 busy FIFO suppresses request", 64'(gts_req), 0);
      ofifo_empty = 1'b1; gts_count = 48'h0;
      wait_n(1);
      chk("R12 count change ignored", 64'(gts_req), 0);
   endtask

   initial begin
      t_reset();
      t_prescale();
      t_source();
      t_enable();
      t_presc_change();
      t_ack();
      t_wrap();
      t_lreq();
      t_gts_off();
      t_gts_fine();
      t_gts_coarse();
      t_gts_pkt();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule